// File: doc/BRIEF.md
# Three-Channel Memory Arbiter

This block lets a processor's instruction-fetch, data-load and data-store channels share one single-ported synchronous memory. All three channels can ask for the memory in the same cycle. The block picks one request per cycle, registers the chosen command towards the memory and tags it. When read data comes back after the memory's fixed latency, the block sends it to the channel that asked for it.

The fetch channel is a stream. A fetch counts as accepted in any cycle where both its request and the grant output are high, and several fetches can be in flight at once. A flush input cancels every fetch accepted before it, so none of their data reaches the fetch output. A fetch presented in the same cycle as the flush is a new request and is served normally. The load and store channels each hold one transaction at a time. The requester keeps its request level high until the matching completion pulse appears. Loads have the highest priority, then stores, then fetches.

Stores are narrowed by a size code. The block turns the size code and the two low address bits into four byte enables and moves the store data onto the selected byte lanes.

Top module: `tri_chan_mem_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ld_valid_o, if_valid_o, st_done_o, mem_en_o and mem_we_o are all low.
- R2: At most one channel is granted per cycle, with priority load over store over fetch. The granted command appears on mem_en_o/mem_we_o/mem_addr_o in the next cycle. A load granted when the block is idle is a read command one cycle after the request is raised.
- R3: A load read issued as a memory command in cycle c produces exactly one ld_valid_o pulse in cycle c+LAT+1, carrying the memory word at that address. The memory returns read data LAT cycles after the command.
- R4: A granted store produces a write command (mem_en_o=1, mem_we_o=1) carrying the store address. st_done_o pulses for one cycle in the same cycle as that command.
- R5: Store size codes are 0 = byte, 1 = halfword and 2 = word. For a byte, the enable is bit a[1:0] and the data byte goes to lane a[1:0]. For a halfword, the enables are 4'b0011 if a[1]=0 or 4'b1100 if a[1]=1, and the halfword goes to that lane pair. For a word, the enables are 4'b1111 and the data is unchanged. Lanes that are not enabled carry zero. Read commands use enables 4'b1111.
- R6: While a load is outstanding (granted, ld_valid_o not yet pulsed), no further load is granted. The same holds for a store and st_done_o.
- R7: if_gnt_o is high exactly when if_req_i is high and neither a load nor a store is granted that cycle. Every accepted fetch that is not cancelled returns exactly one if_valid_o pulse carrying the memory word at its address, in acceptance order, with none lost.
- R8: No fetch accepted before a cycle with if_flush_i high, and not yet shown on if_valid_o by that cycle, ever produces an if_valid_o pulse. A fetch accepted in the flush cycle itself is delivered.
- R9: A store request is completed within LAT+4 cycles of being raised, and a load request within 2*LAT+6 cycles.
- R10: Responses go only to the issuer. ld_valid_o pulses only while a load is outstanding, st_done_o only for a pending store, and if_valid_o only for a fetch still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req_i | input | 1 | Fetch request |
| if_flush_i | input | 1 | Cancel all earlier fetches |
| if_addr_i | input | AW | Fetch byte address |
| if_gnt_o | output | 1 | Fetch accepted this cycle |
| if_valid_o | output | 1 | Fetched word valid |
| if_instr_o | output | 32 | Fetched word |
| ld_req_i | input | 1 | Load request, held until ld_valid_o |
| ld_addr_i | input | AW | Load byte address |
| ld_valid_o | output | 1 | Load data valid |
| ld_data_o | output | 32 | Load data |
| st_req_i | input | 1 | Store request, held until st_done_o |
| st_addr_i | input | AW | Store byte address |
| st_data_i | input | 32 | Store data, right-aligned |
| st_size_i | input | 2 | Store size code |
| st_done_o | output | 1 | Store completed |
| mem_en_o | output | 1 | Memory command valid |
| mem_we_o | output | 1 | Memory command is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data, lane-placed |
| mem_be_o | output | 4 | Memory byte enables |
| mem_rdata_i | input | 32 | Memory read data, LAT cycles after the command |

## Verification
The assertions assume the requesters follow the protocol. Load and store requests stay high with stable address and data until their completion pulse, and then drop. The memory returns read data exactly LAT cycles after each read command. The bench's memory model has exactly that fixed latency. Its load and store agents raise a request only when idle, hold it until completion, and lower it in the completion cycle. Random loads and fetches read a region that no store touches, so every expected word is known without any ordering between channels.

// File: rtl/arb3_pkg.sv
package arb3_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_FETCH = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // byte enables from size code and low address bits
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << lo;
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // place right-aligned store data onto its byte lanes
  function automatic logic [DATA_W-1:0] lane_data(input logic [1:0] sz,
                                                  input logic [1:0] lo,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    case (sz)
      SZ_BYTE: r = {24'd0, d[7:0]} << {lo, 3'b000};
      SZ_HALF: r = {16'd0, d[15:0]} << {lo[1], 4'b0000};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/arb3_grant.sv
module arb3_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req,
  input  logic st_req,
  input  logic f_req,
  input  logic ld_resp,
  input  logic st_resp,
  output logic ld_gnt,
  output logic st_gnt,
  output logic f_gnt,
  output logic ld_busy,
  output logic st_busy
);

  logic ld_cand, st_cand;

  always_comb begin
    ld_cand = ld_req && !ld_busy;
    st_cand = st_req && !st_busy;
    ld_gnt  = ld_cand;
    st_gnt  = st_cand && !ld_cand;
    f_gnt   = f_req && !ld_cand && !st_cand;
  end

  // one outstanding transaction per data channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_busy <= 1'b0;
      st_busy <= 1'b0;
    end else begin
      if (ld_gnt)       ld_busy <= 1'b1;
      else if (ld_resp) ld_busy <= 1'b0;
      if (st_gnt)       st_busy <= 1'b1;
      else if (st_resp) st_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/arb3_resp_pipe.sv
module arb3_resp_pipe
  import arb3_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  kind_t issue_kind,
  output kind_t ret_kind
);

  kind_t stage_q [LAT];

  generate
    for (genvar k = 0; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= K_NONE;
        else if (k == 0) stage_q[k] <= issue_kind;
        else stage_q[k] <= stage_q[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  assign ret_kind = stage_q[LAT-1];

endmodule

// File: rtl/arb3_flush_track.sv
module arb3_flush_track #(
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_gnt,
  input  logic          fret,
  input  logic          flush,
  output logic          fwd,
  output logic [CW-1:0] inflight,
  output logic [CW-1:0] drop_cnt
);

  logic [CW-1:0] inflight_n, drop_n;

  always_comb begin
    fwd        = !flush && (drop_cnt == '0);
    inflight_n = inflight + CW'(f_gnt) - CW'(fret);
    if (flush)
      drop_n = inflight - CW'(fret);
    else if (fret && (drop_cnt != '0))
      drop_n = drop_cnt - 1'b1;
    else
      drop_n = drop_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
      drop_cnt <= '0;
    end else begin
      inflight <= inflight_n;
      drop_cnt <= drop_n;
    end
  end

endmodule

// File: rtl/tri_chan_mem_arb.sv
module tri_chan_mem_arb
  import arb3_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_req_i,
  input  logic              if_flush_i,
  input  logic [AW-1:0]     if_addr_i,
  output logic              if_gnt_o,
  output logic              if_valid_o,
  output logic [DATA_W-1:0] if_instr_o,
  input  logic              ld_req_i,
  input  logic [AW-1:0]     ld_addr_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  input  logic              st_req_i,
  input  logic [AW-1:0]     st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [1:0]        st_size_i,
  output logic              st_done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  // named internal events
  logic          ld_gnt, st_gnt, f_gnt;
  logic          ld_busy, st_busy;
  logic          fret, lret, fwd;
  logic [CW-1:0] inflight, drop_cnt;
  kind_t         cmd_kind, issue_kind, ret_kind;

  arb3_grant u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_req  (ld_req_i),
    .st_req  (st_req_i && !st_done_o),
    .f_req   (if_req_i),
    .ld_resp (ld_valid_o),
    .st_resp (st_done_o),
    .ld_gnt  (ld_gnt),
    .st_gnt  (st_gnt),
    .f_gnt   (f_gnt),
    .ld_busy (ld_busy),
    .st_busy (st_busy)
  );

  assign if_gnt_o = f_gnt;

  // registered memory command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
      cmd_kind    <= K_NONE;
      st_done_o   <= 1'b0;
    end else begin
      mem_en_o  <= ld_gnt || st_gnt || f_gnt;
      mem_we_o  <= st_gnt;
      st_done_o <= st_gnt;
      if (ld_gnt) begin
        mem_addr_o  <= ld_addr_i;
        mem_wdata_o <= '0;
        mem_be_o    <= '1;
        cmd_kind    <= K_LOAD;
      end else if (st_gnt) begin
        mem_addr_o  <= st_addr_i;
        mem_wdata_o <= lane_data(st_size_i, st_addr_i[1:0], st_data_i);
        mem_be_o    <= lane_mask(st_size_i, st_addr_i[1:0]);
        cmd_kind    <= K_STORE;
      end else if (f_gnt) begin
        mem_addr_o  <= if_addr_i;
        mem_wdata_o <= '0;
        mem_be_o    <= '1;
        cmd_kind    <= K_FETCH;
      end else begin
        cmd_kind    <= K_NONE;
      end
    end
  end

  assign issue_kind = (mem_en_o && !mem_we_o) ? cmd_kind : K_NONE;

  arb3_resp_pipe #(.LAT(LAT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_kind (issue_kind),
    .ret_kind   (ret_kind)
  );

  assign fret = (ret_kind == K_FETCH);
  assign lret = (ret_kind == K_LOAD);

  arb3_flush_track #(.LAT(LAT)) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .f_gnt    (f_gnt),
    .fret     (fret),
    .flush    (if_flush_i),
    .fwd      (fwd),
    .inflight (inflight),
    .drop_cnt (drop_cnt)
  );

  // registered responses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
      if_valid_o <= 1'b0;
      if_instr_o <= '0;
    end else begin
      ld_valid_o <= lret;
      if (lret) ld_data_o <= mem_rdata_i;
      if_valid_o <= fret && fwd;
      if (fret && fwd) if_instr_o <= mem_rdata_i;
    end
  end

endmodule

// File: rtl/arb3_checks.sv
module arb3_checks #(
  parameter int LAT = 2,
  parameter int CW  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_req_i,
  input logic          if_flush_i,
  input logic          if_gnt_o,
  input logic          if_valid_o,
  input logic          ld_req_i,
  input logic          ld_valid_o,
  input logic          st_req_i,
  input logic          st_done_o,
  input logic          mem_en_o,
  input logic          mem_we_o,
  input logic [3:0]    mem_be_o,
  input logic          ld_gnt,
  input logic          st_gnt,
  input logic          f_gnt,
  input logic          ld_busy,
  input logic          st_busy,
  input logic          fret,
  input logic [CW-1:0] drop_cnt
);

  localparam int LIMIT = LAT + 4;
  localparam int WW    = $clog2(LIMIT + 2);

  logic [WW-1:0] st_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_wait <= '0;
    else if (st_done_o || !st_req_i) st_wait <= '0;
    else if (st_wait != WW'(LIMIT + 1)) st_wait <= st_wait + 1'b1;
  end

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_gnt, st_gnt, f_gnt}));
  p_load_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req_i && !ld_busy) |-> (!st_gnt && !if_gnt_o));
  p_store_over_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_i && !st_busy && !st_done_o) |-> !if_gnt_o);
  p_cmd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_gnt || st_gnt || f_gnt) |=> mem_en_o);
  p_ld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |=> !ld_valid_o);
  p_done_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_done_o |-> (mem_en_o && mem_we_o));
  p_write_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o) |-> (mem_be_o != 4'b0000));
  p_read_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |-> (mem_be_o == 4'b1111));
  p_single_ld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |-> !ld_gnt);
  p_single_st_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !st_gnt);
  p_fetch_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_i && !ld_gnt && !st_gnt) |-> if_gnt_o);
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fret && (drop_cnt != '0 || if_flush_i)) |=> !if_valid_o);
  p_store_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait <= WW'(LIMIT));
  p_route_ld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> ld_busy);
  p_route_if_r10: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid_o |-> $past(fret));

endmodule

bind tri_chan_mem_arb arb3_checks #(.LAT(LAT), .CW(CW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .if_req_i   (if_req_i),
  .if_flush_i (if_flush_i),
  .if_gnt_o   (if_gnt_o),
  .if_valid_o (if_valid_o),
  .ld_req_i   (ld_req_i),
  .ld_valid_o (ld_valid_o),
  .st_req_i   (st_req_i),
  .st_done_o  (st_done_o),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o),
  .ld_gnt     (ld_gnt),
  .st_gnt     (st_gnt),
  .f_gnt      (f_gnt),
  .ld_busy    (ld_busy),
  .st_busy    (st_busy),
  .fret       (fret),
  .drop_cnt   (drop_cnt)
);

// File: tb/tb_tri_chan_mem_arb.sv
`timescale 1ns/1ps
module tb_tri_chan_mem_arb;

  localparam int AW  = 32;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic if_req_i, if_flush_i, if_gnt_o, if_valid_o;
  logic [AW-1:0] if_addr_i;
  logic [31:0] if_instr_o;
  logic ld_req_i, ld_valid_o;
  logic [AW-1:0] ld_addr_i;
  logic [31:0] ld_data_o;
  logic st_req_i, st_done_o;
  logic [AW-1:0] st_addr_i;
  logic [31:0] st_data_i;
  logic [1:0] st_size_i;
  logic mem_en_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic [3:0] mem_be_o;

  always #4 clk = ~clk;

  tri_chan_mem_arb #(.AW(AW), .LAT(LAT)) dut (.*);

  // memory model: fixed read latency LAT
  logic [31:0] mem [256];
  logic [31:0] rpipe [LAT];
  always @(posedge clk) begin
    if (mem_en_o && mem_we_o)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    rpipe[0] <= mem[mem_addr_o[9:2]];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end
  assign mem_rdata_i = rpipe[LAT-1];

  int total = 0, bad = 0;

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h0101_0107) ^ 32'h1F2E_3D4C;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'(1 << lo);
    if (sz == 2'd1) return (lo >= 2) ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] lo,
                                         input logic [31:0] d);
    logic [31:0] r = '0;
    int base = (sz == 2'd0) ? int'(lo) : (sz == 2'd1) ? int'(lo & 2'b10) : 0;
    logic [3:0] m = exp_be(sz, lo);
    for (int b = 0; b < 4; b++)
      if (m[b]) r[8*b +: 8] = d[8*(b-base) +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // random-phase agent state
  bit ld_wait, st_wait;
  int ld_idx, ld_age, st_age, f_idx;
  logic [31:0] st_exp_a, st_exp_d;
  logic [3:0]  st_exp_b;
  int fq[$];

  task automatic step(input bit stim);
    int e;
    @(negedge clk);
    if (ld_wait) ld_age++;
    if (st_wait) st_age++;
    if (ld_valid_o) begin
      check(ld_wait, "R10 load valid without request", 32'(ld_valid_o), 32'(ld_wait));
      check(ld_data_o == pat(ld_idx), "R3 load data", ld_data_o, pat(ld_idx));
      check(ld_age <= 2*LAT+6, "R9 load bound", ld_age, 2*LAT+6);
      ld_wait = 0; ld_req_i = 0;
    end
    if (st_done_o) begin
      check(st_wait, "R10 done without store", 32'(st_done_o), 32'(st_wait));
      check(mem_addr_o == st_exp_a, "R4 store addr", mem_addr_o, st_exp_a);
      check(mem_be_o == st_exp_b, "R5 store enables", 32'(mem_be_o), 32'(st_exp_b));
      check(mem_wdata_o == st_exp_d, "R5 store lanes", mem_wdata_o, st_exp_d);
      check(st_age <= LAT+4, "R9 store bound", st_age, LAT+4);
      st_wait = 0; st_req_i = 0;
    end
    if (if_valid_o) begin
      check(fq.size() != 0, "R10 fetch valid not in flight", 32'(if_valid_o), 0);
      if (fq.size() != 0) begin
        e = fq.pop_front();
        check(if_instr_o == pat(e), "R7 fetch order/data", if_instr_o, pat(e));
      end
    end
    if_flush_i = 0;
    if (stim) begin
      if (!ld_wait && !ld_valid_o && ($urandom % 3 == 0)) begin
        ld_idx = $urandom % 128; ld_addr_i = 32'(ld_idx * 4);
        ld_req_i = 1; ld_wait = 1; ld_age = 0;
      end
      if (!st_wait && !st_done_o && ($urandom % 3 == 0)) begin
        st_size_i = 2'($urandom % 3);
        st_addr_i = 32'((128 + $urandom % 128) * 4 + $urandom % 4);
        st_data_i = $urandom;
        st_exp_a = st_addr_i;
        st_exp_b = exp_be(st_size_i, st_addr_i[1:0]);
        st_exp_d = exp_wd(st_size_i, st_addr_i[1:0], st_data_i);
        st_req_i = 1; st_wait = 1; st_age = 0;
      end
      if_req_i  = ($urandom % 4 != 0);
      if_addr_i = 32'(f_idx * 4);
      if ($urandom % 16 == 0) begin
        if_flush_i = 1;
        fq.delete();
      end
    end else begin
      if_req_i = 0;
    end
    #1;
    if (if_req_i && if_gnt_o) begin
      fq.push_back(f_idx);
      f_idx = (f_idx + 1) % 128;
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                          input logic [3:0] be, input logic [31:0] wd);
    int n = 0;
    @(negedge clk);
    st_addr_i = a; st_data_i = d; st_size_i = sz; st_req_i = 1;
    do begin @(negedge clk); n++; end while (!st_done_o && n < 20);
    check(mem_we_o && mem_addr_o == a, "R4 write command", mem_addr_o, a);
    check(mem_be_o == be, "R5 enables", 32'(mem_be_o), 32'(be));
    check(mem_wdata_o == wd, "R5 lane data", mem_wdata_o, wd);
    st_req_i = 0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [31:0] exp);
    int n = 0;
    @(negedge clk);
    ld_addr_i = a; ld_req_i = 1;
    do begin @(negedge clk); n++; end while (!ld_valid_o && n < 20);
    check(n == LAT+2, "R3 load latency", n, LAT+2);
    check(ld_data_o == exp, "R3 load word", ld_data_o, exp);
    ld_req_i = 0;
  endtask

  initial begin
    int n, cnt;
    logic [31:0] got;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    for (int k = 0; k < LAT; k++) rpipe[k] = '0;
    rst_n = 0;
    if_req_i = 0; if_flush_i = 0; if_addr_i = 0;
    ld_req_i = 0; ld_addr_i = 0;
    st_req_i = 0; st_addr_i = 0; st_data_i = 0; st_size_i = 0;
    repeat (3) begin
      @(negedge clk);
      check({ld_valid_o, if_valid_o, st_done_o, mem_en_o, mem_we_o} == 0, "R1 reset outputs",
            32'({ld_valid_o, if_valid_o, st_done_o, mem_en_o, mem_we_o}), 0);
    end
    rst_n = 1;
    @(negedge clk);
    check({ld_valid_o, if_valid_o, st_done_o, mem_en_o, mem_we_o} == 0, "R1 after reset",
          32'({ld_valid_o, if_valid_o, st_done_o, mem_en_o, mem_we_o}), 0);

    // R2 priority: all three at once
    ld_addr_i = 32'(5*4); ld_req_i = 1;
    st_addr_i = 32'(130*4 + 1); st_data_i = 32'h0000_00A5; st_size_i = 2'd0; st_req_i = 1;
    if_addr_i = 32'(10*4); if_req_i = 1;
    #1 check(!if_gnt_o, "R2 fetch loses to load", 32'(if_gnt_o), 0);
    @(negedge clk);
    check(mem_en_o && !mem_we_o && mem_addr_o == 32'(5*4), "R2 load first", mem_addr_o, 32'(5*4));
    #1 check(!if_gnt_o, "R2 fetch loses to store", 32'(if_gnt_o), 0);
    @(negedge clk);
    check(mem_we_o && st_done_o, "R4 store second", 32'({mem_we_o, st_done_o}), 3);
    check(mem_be_o == 4'b0010, "R5 byte lane 1", 32'(mem_be_o), 2);
    check(mem_wdata_o == 32'h0000_A500, "R5 byte data", mem_wdata_o, 32'h0000_A500);
    st_req_i = 0;
    #1 check(if_gnt_o, "R7 fetch granted when free", 32'(if_gnt_o), 1);
    @(negedge clk); if_req_i = 0;
    n = 1;
    while (!ld_valid_o && n < 10) begin @(negedge clk); n++; end
    check(n == LAT, "R3 load return cycle", n, LAT);
    check(ld_data_o == pat(5), "R3 load data", ld_data_o, pat(5));
    ld_req_i = 0;
    n = 0;
    while (!if_valid_o && n < 10) begin @(negedge clk); n++; end
    check(if_instr_o == pat(10), "R7 fetch data", if_instr_o, pat(10));
    repeat (4) @(negedge clk);

    // R5 sizes and store-then-load
    do_store(32'(140*4 + 2), 32'h1234_BEEF, 2'd1, 4'b1100, 32'hBEEF_0000);
    do_load(32'(140*4), {16'hBEEF, pat(140)[15:0]});
    do_store(32'(141*4), 32'hCAFE_F00D, 2'd2, 4'b1111, 32'hCAFE_F00D);
    do_load(32'(141*4), 32'hCAFE_F00D);
    do_store(32'(142*4 + 3), 32'h0000_0077, 2'd0, 4'b1000, 32'h7700_0000);
    do_load(32'(142*4), {8'h77, pat(142)[23:0]});
    do_store(32'(143*4 + 1), 32'h0000_5566, 2'd1, 4'b0011, 32'h0000_5566);

    // R8 flush with three fetches in flight and a new one in the flush cycle
    repeat (3) @(negedge clk);
    cnt = 0; got = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (if_valid_o) begin cnt++; got = if_instr_o; end
      if_req_i = 1; if_addr_i = 32'((20 + i) * 4); if_flush_i = (i == 3);
    end
    @(negedge clk);
    if (if_valid_o) begin cnt++; got = if_instr_o; end
    if_req_i = 0; if_flush_i = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (if_valid_o) begin cnt++; got = if_instr_o; end
    end
    check(cnt == 1, "R8 stale fetches dropped", cnt, 1);
    check(got == pat(23), "R8 flush-cycle fetch kept", got, pat(23));

    // random phase
    f_idx = 0; ld_wait = 0; st_wait = 0;
    for (int c = 0; c < 4000; c++) step(1'b1);
    for (int c = 0; c < 20; c++) step(1'b0);
    check(fq.size() == 0, "R7 no fetch lost", fq.size(), 0);
    check(!ld_wait && !st_wait, "R9 all data ops done", 32'({ld_wait, st_wait}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule